// File: doc/BRIEF.md
# Pipelined Line-Sum Accumulator

The block adds up a serial stream of integer words, one word per cycle in which `valid_i` is high and `ready_o` is high. Words are grouped into lines. The word that arrives with `eol_i` high is the last word of its line. For each line the block returns one total on `sum_o`, and `sum_valid_o` is high for exactly one cycle to mark it. Every adder inside the block is pipelined with a latency of `LAT` cycles, so no adder ever has to feed its own result back within a single cycle.

The front end collects words into groups of `LAT` words using a chain of `LAT-1` registers, with the live input as the last word of the group. Each group is handed to a reduction tree with `LAT+1` leaves. The spare leaf is tied to zero. At each layer the words are added in pairs; when a layer has an odd word left over, a delay stage with the same latency as an adder carries it forward. The tree's partial sums, at least `LAT` cycles apart, go into a final adder that feeds back on itself and builds the line total.

When a line ends partway through a group, the empty slots read as zero. That short group is sent to the tree as soon as `LAT` cycles have passed since the previous group. After the end-of-line word is accepted, `ready_o` stays low until the total has been delivered, so two lines are never mixed.

Top module: `stream_accum`

## Requirements
- R1: After reset, `ready_o` is 1, `sum_valid_o` is 0 and `sum_o` is 0.
- R2: Each line produces exactly one `sum_valid_o` pulse, one cycle wide. `sum_o` in that cycle equals the sum of the line's accepted words.
- R3: Let D = ceil(log2(LAT+1)). When the end-of-line word completes a full group of LAT words, `sum_valid_o` is seen high at the (D+1)*LAT-th rising edge after the edge that accepts that word. With the defaults (LAT=4, D=3) that is 16 edges.
- R4: When the last group of a line is partial, that group enters the tree at the first edge after the end-of-line edge that is also at least LAT edges after the previous group of the line. Two cases with LAT=4: a one-word line gives its result 17 edges after its end-of-line edge; a line of LAT+1 back-to-back words gives 19.
- R5: Slots left empty by a partial group add zero. No word from an earlier group or an earlier line leaks into a later total.
- R6: From the edge that accepts an end-of-line word until the result pulse, `ready_o` is 0. Any `valid_i`, `data_i` or `eol_i` activity while `ready_o` is 0 is ignored.
- R7: A cycle with `valid_i` low adds nothing and does not advance the group.
- R8: In the cycle after the `sum_valid_o` pulse, `ready_o` is 1 again.
- R9: Sums wrap modulo 2^W. For example, five words of all ones (W=32) give 32'hFFFF_FFFB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | W | Operand word |
| valid_i | input | 1 | Operand present this cycle |
| eol_i | input | 1 | Operand is the last word of its line |
| ready_o | output | 1 | Block accepts an operand this cycle |
| sum_o | output | W | Line total, meaningful while sum_valid_o is high |
| sum_valid_o | output | 1 | One-cycle pulse marking a completed line total |

## Verification
The assertions assume that every line ends with a word carrying `eol_i`. They also assume that a word counts only in a cycle where both `valid_i` and `ready_o` are high, so the final adder never receives two partial sums closer together than LAT cycles. The stimulus sends real words only while `ready_o` is high. While the block is draining, it deliberately drives junk words with random end-of-line flags; these must be ignored. Line lengths are drawn across, below and above multiples of LAT, with idle cycles mixed in at random. Exact-latency cases are sent back to back so that the expected edge counts hold.

// File: rtl/accum_pkg.sv
package accum_pkg;

  typedef struct packed {
    logic vld;
    logic last;
  } tag_t;

  // words left after lvl halving steps (adders plus odd carry)
  function automatic int layer_width(input int leaves, input int lvl);
    int w;
    w = leaves;
    for (int i = 0; i < lvl; i++) w = (w + 1) / 2;
    return w;
  endfunction

  function automatic int tree_depth(input int leaves);
    int w;
    int d;
    w = leaves;
    d = 0;
    while (w > 1) begin
      w = (w + 1) / 2;
      d++;
    end
    return d;
  endfunction

endpackage

// File: rtl/pipe_stage.sv
// NIN=2: pipelined adder, NIN=1: matched delay stage
module pipe_stage #(
  parameter int W   = 32,
  parameter int LAT = 4,
  parameter int NIN = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i [NIN],
  output logic [W-1:0] out_o
);

  logic [W-1:0] comb_sum;
  logic [W-1:0] stg_q [LAT];

  always_comb begin
    comb_sum = '0;
    for (int i = 0; i < NIN; i++) comb_sum = comb_sum + in_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < LAT; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= comb_sum;
      for (int k = 1; k < LAT; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign out_o = stg_q[LAT-1];

endmodule

// File: rtl/line_gather.sv
module line_gather #(
  parameter int W   = 32,
  parameter int LAT = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         valid_i,
  input  logic         eol_i,
  input  logic         done_i,
  output logic         ready_o,
  output logic [W-1:0] leaves_o [LAT+1],
  output logic         cap_o,
  output logic         last_o
);

  localparam int CW = $clog2(LAT + 1);

  logic [W-1:0]  sh_q [LAT-1];
  logic [CW-1:0] slot_q;
  logic [CW-1:0] gap_q;
  logic          closing_q;
  logic          busy_q;
  logic          accept;
  logic          full_cap;
  logic          flush_cap;

  assign ready_o   = !closing_q && !busy_q;
  assign accept    = valid_i && ready_o;
  assign full_cap  = accept && (slot_q == CW'(LAT - 1));
  // partial tail waits until the final adder can take it
  assign flush_cap = closing_q && (gap_q == CW'(LAT));
  assign cap_o     = full_cap || flush_cap;
  assign last_o    = full_cap ? eol_i : 1'b1;

  always_comb begin
    leaves_o[0] = full_cap ? data_i : '0;
    for (int k = 1; k < LAT; k++) leaves_o[k] = sh_q[k-1];
    leaves_o[LAT] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < LAT - 1; k++) sh_q[k] <= '0;
      slot_q    <= '0;
      gap_q     <= CW'(LAT);
      closing_q <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      if (cap_o) begin
        for (int k = 0; k < LAT - 1; k++) sh_q[k] <= '0;
        slot_q <= '0;
        gap_q  <= CW'(1);
      end else begin
        if (accept) begin
          sh_q[0] <= data_i;
          for (int k = 1; k < LAT - 1; k++) sh_q[k] <= sh_q[k-1];
          slot_q <= slot_q + CW'(1);
        end
        if (gap_q != CW'(LAT)) gap_q <= gap_q + CW'(1);
      end
      if (accept && eol_i && !full_cap) closing_q <= 1'b1;
      else if (flush_cap)               closing_q <= 1'b0;
      if (cap_o && last_o) busy_q <= 1'b1;
      else if (done_i)     busy_q <= 1'b0;
    end
  end

  // R6
  eol_holdoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && eol_i) |=> !ready_o);

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !closing_q) |=> $stable(slot_q));

endmodule

// File: rtl/reduce_tree.sv
module reduce_tree #(
  parameter int W   = 32,
  parameter int LAT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      leaves_i [LAT+1],
  input  accum_pkg::tag_t   tag_i,
  output logic [W-1:0]      sum_o,
  output accum_pkg::tag_t   tag_o
);

  localparam int LEAVES = LAT + 1;
  localparam int DEPTH  = accum_pkg::tree_depth(LEAVES);

  for (genvar l = 0; l <= DEPTH; l++) begin : lvl_g
    localparam int WL = accum_pkg::layer_width(LEAVES, l);
    logic [W-1:0] w [WL];
    if (l == 0) begin : src_g
      for (genvar j = 0; j < WL; j++) begin : cp_g
        assign w[j] = leaves_i[j];
      end
    end else begin : node_g
      localparam int WP = accum_pkg::layer_width(LEAVES, l - 1);
      for (genvar j = 0; j < WL; j++) begin : n_g
        if (2 * j + 1 < WP) begin : add_g
          logic [W-1:0] pr [2];
          assign pr[0] = lvl_g[l-1].w[2*j];
          assign pr[1] = lvl_g[l-1].w[2*j+1];
          pipe_stage #(.W(W), .LAT(LAT), .NIN(2)) u_add (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .in_i  (pr),
            .out_o (w[j])
          );
        end else begin : dly_g
          logic [W-1:0] pr [1];
          assign pr[0] = lvl_g[l-1].w[2*j];
          pipe_stage #(.W(W), .LAT(LAT), .NIN(1)) u_dly (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .in_i  (pr),
            .out_o (w[j])
          );
        end
      end
    end
  end

  assign sum_o = lvl_g[DEPTH].w[0];

  logic [1:0] tag_in [1];
  logic [1:0] tag_out;
  assign tag_in[0] = tag_i;

  pipe_stage #(.W(2), .LAT(DEPTH * LAT), .NIN(1)) u_tag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (tag_in),
    .out_o (tag_out)
  );

  assign tag_o = accum_pkg::tag_t'(tag_out);

endmodule

// File: rtl/stream_accum.sv
module stream_accum #(
  parameter int W   = 32,
  parameter int LAT = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         valid_i,
  input  logic         eol_i,
  output logic         ready_o,
  output logic [W-1:0] sum_o,
  output logic         sum_valid_o
);

  localparam int CW = $clog2(LAT + 1);

  logic [W-1:0]    leaves [LAT+1];
  logic            cap;
  logic            cap_last;
  accum_pkg::tag_t cap_tag;
  logic [W-1:0]    tree_sum;
  accum_pkg::tag_t tree_tag;
  logic [W-1:0]    fa_sum;
  accum_pkg::tag_t fa_tag;
  logic [W-1:0]    acc_q;
  logic [W-1:0]    fb;
  logic [W-1:0]    fa_in [2];
  logic [1:0]      fa_tag_in [1];
  logic [1:0]      fa_tag_out;

  line_gather #(.W(W), .LAT(LAT)) u_gather (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (data_i),
    .valid_i (valid_i),
    .eol_i   (eol_i),
    .done_i  (sum_valid_o),
    .ready_o (ready_o),
    .leaves_o(leaves),
    .cap_o   (cap),
    .last_o  (cap_last)
  );

  assign cap_tag.vld  = cap;
  assign cap_tag.last = cap && cap_last;

  reduce_tree #(.W(W), .LAT(LAT)) u_tree (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .leaves_i(leaves),
    .tag_i   (cap_tag),
    .sum_o   (tree_sum),
    .tag_o   (tree_tag)
  );

  // bypass: a result leaving the pipe this cycle is the freshest partial
  assign fb       = fa_tag.vld ? fa_sum : acc_q;
  assign fa_in[0] = tree_tag.vld ? tree_sum : '0;
  assign fa_in[1] = tree_tag.vld ? fb : '0;
  assign fa_tag_in[0] = tree_tag;

  pipe_stage #(.W(W), .LAT(LAT), .NIN(2)) u_final (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (fa_in),
    .out_o (fa_sum)
  );

  pipe_stage #(.W(2), .LAT(LAT), .NIN(1)) u_final_tag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (fa_tag_in),
    .out_o (fa_tag_out)
  );

  assign fa_tag = accum_pkg::tag_t'(fa_tag_out);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   acc_q <= '0;
    else if (fa_tag.vld && fa_tag.last) acc_q <= '0;
    else if (fa_tag.vld)           acc_q <= fa_sum;
  end

  assign sum_o       = fa_sum;
  assign sum_valid_o = fa_tag.vld && fa_tag.last;

  // checker counter: cycles since the tree last delivered a partial
  logic [CW-1:0] spc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               spc_q <= CW'(LAT);
    else if (tree_tag.vld)     spc_q <= CW'(1);
    else if (spc_q != CW'(LAT)) spc_q <= spc_q + CW'(1);
  end

  // R4
  group_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tree_tag.vld |-> (spc_q == CW'(LAT)));

  // R2
  one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_valid_o |=> !sum_valid_o);

  // R8
  ready_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_valid_o |=> ready_o);

endmodule

// File: tb/stream_accum_bench.sv
module stream_accum_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 32;
  localparam int LAT = 4;

  function automatic int clog2i(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  localparam int DEP    = clog2i(LAT + 1);
  localparam int L_FULL = (DEP + 1) * LAT;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         valid_i = 1'b0;
  logic         eol_i = 1'b0;
  logic         ready_o;
  logic [W-1:0] sum_o;
  logic         sum_valid_o;

  stream_accum #(.W(W), .LAT(LAT)) u_stream_accum (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .data_i     (data_i),
    .valid_i    (valid_i),
    .eol_i      (eol_i),
    .ready_o    (ready_o),
    .sum_o      (sum_o),
    .sum_valid_o(sum_valid_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int eol_cyc = 0;
  int lines = 0;
  int pulses = 0;
  bit prev_sv = 1'b0;
  logic [W-1:0] exp_q [$];
  int           lat_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] line_total(input logic [W-1:0] ws [$]);
    logic [W-1:0] s;
    s = '0;
    foreach (ws[i]) s = s + ws[i];
    return s;
  endfunction

  // result monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_sv) begin
        chk(ready_o === 1'b1, "R8", ready_o, 1);
        chk(sum_valid_o === 1'b0, "R2 pulse width", sum_valid_o, 0);
      end
      if (sum_valid_o) begin
        pulses++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 extra pulse", 1, 0);
        end else begin
          logic [W-1:0] e;
          int           l;
          e = exp_q.pop_front();
          l = lat_q.pop_front();
          chk(sum_o == e, "R2 sum", sum_o, e);
          if (l >= 0) chk((cyc - eol_cyc + 1) == l, "R3/R4 latency", cyc - eol_cyc + 1, l);
        end
      end
      prev_sv = sum_valid_o;
    end
  end

  // drives one word at a negedge; junk is sent while the block is not ready
  task automatic put(input logic [W-1:0] d, input bit e, input bit junk);
    while (!ready_o) begin
      valid_i = junk;
      data_i  = $urandom;
      eol_i   = junk ? 1'($urandom) : 1'b0;
      @(negedge clk);
    end
    valid_i = 1'b1;
    data_i  = d;
    eol_i   = e;
    @(negedge clk);
    valid_i = 1'b0;
    eol_i   = 1'b0;
    data_i  = '0;
    if (e) begin
      eol_cyc = cyc;
      chk(ready_o == 1'b0, "R6 holdoff", ready_o, 0);
    end
  endtask

  task automatic send_line(input logic [W-1:0] ws [$], input int gap_pct,
                           input bit junk, input int lat);
    foreach (ws[i]) begin
      while (($urandom % 100) < gap_pct) @(negedge clk); // R7 idle cycles
      put(ws[i], i == ws.size() - 1, junk);
    end
    exp_q.push_back(line_total(ws));
    lat_q.push_back(lat);
    lines++;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0 || !ready_o) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] ws [$];
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready_o == 1'b1, "R1 ready", ready_o, 1);
    chk(sum_valid_o == 1'b0, "R1 valid", sum_valid_o, 0);
    chk(sum_o == '0, "R1 sum", sum_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready_o == 1'b1, "R1 ready after release", ready_o, 1);

    // R3 exact group, back to back
    ws = {32'd1, 32'd2, 32'd3, 32'd4};
    send_line(ws, 0, 0, L_FULL);
    wait_drain();
    // R3 two full groups
    ws = {32'd10, 32'd20, 32'd30, 32'd40, 32'd50, 32'd60, 32'd70, 32'd80};
    send_line(ws, 0, 0, L_FULL);
    wait_drain();
    // R4 one-word line
    ws = {32'h1234_5678};
    send_line(ws, 0, 0, L_FULL + 1);
    wait_drain();
    // R4 LAT+1 back to back: tail waits for group spacing
    ws = {32'd5, 32'd6, 32'd7, 32'd8, 32'd9};
    send_line(ws, 0, 0, L_FULL + LAT - 1);
    wait_drain();
    // R9 wrap
    ws = {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
    send_line(ws, 0, 0, -1);
    wait_drain();
    chk(1'b1, "R9 covered by R2 sum FFFFFFFB", 0, 0);
    // R5 short line after a long line of large words
    ws = {};
    for (int i = 0; i < 3 * LAT - 1; i++) ws.push_back(32'hF0F0_0000 + W'(i));
    send_line(ws, 0, 0, -1);
    ws = {32'd7, 32'd9};
    send_line(ws, 0, 1, -1); // R6 junk during drain of previous line
    wait_drain();

    // random lines with idle gaps and junk while busy
    for (int n = 0; n < 60; n++) begin
      int len;
      len = 1 + int'($urandom % (3 * LAT + 2));
      ws = {};
      for (int i = 0; i < len; i++) ws.push_back($urandom);
      send_line(ws, 25, 1'($urandom), -1);
    end
    wait_drain();
    repeat (5) @(negedge clk);
    chk(pulses == lines, "R2 pulse count", pulses, lines);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule